// File: doc/BRIEF.md
# Status Register Write-Protection Unit

This unit keeps the one-byte status word of a serial nonvolatile memory and decides, from that word and the write-protect pin, whether the memory array or the status word itself may be written. A command engine elsewhere decodes the serial instructions. It feeds this unit one-cycle strobes: enable writes, disable writes, set the flag, status write with its data byte, and the end of a timed write. It also supplies the busy level of its write timer and the page address it captured for an array write.

The unit returns the status byte for readback, an array write grant for the presented address and a status write grant. The lock bits and the pin-enable bit stand in for nonvolatile cells. They are ordinary registers that take preset parameter values at reset. A status write the unit accepts is held pending and takes effect when the write timer reports completion. The pin can no longer cancel it after it has been accepted.

Top module: `sr_guard`

## Requirements
- R1: Synchronous active-low reset brings the status byte to {PIN_EN_INIT, 0, 1, 1, LOCK_INIT, 0, busy}. With default parameters this is 0x30 when the timer is idle.
- R2: A write-enable strobe sets the enable-latch bit (bit 1) at the next clock edge. A write-disable strobe clears it. Clearing takes priority when both are present.
- R3: A set-flag strobe sets the flag bit (bit 6) at the next edge. A write-disable strobe clears it, with priority over setting.
- R4: A write-done strobe clears the enable-latch bit at the next edge, overriding a simultaneous write-enable strobe.
- R5: Bit 0 follows the timer busy input in the same cycle, without a register.
- R6: Bits 5 and 4 always read 1. A status write changes only bit 7 (pin enable) and bits 3:2 (lock field). Written bits 6, 5, 4, 1 and 0 have no effect on the byte.
- R7: The array write grant is 0 whenever the enable latch is 0.
- R8: With the latch set and a 13-bit address, the lock field decides the grant. 00 grants every address. 01 refuses 0x1800–0x1FFF. 10 refuses 0x1000–0x1FFF. 11 refuses all addresses.
- R9: The status write grant equals latch AND NOT (pin-enable bit AND pin low), evaluated in the same cycle.
- R10: A status write strobe arriving while the grant is 1 is accepted. Its bit 7 and bits 3:2 land in the byte at the edge of the next write-done strobe, even if the pin has gone low in between. A strobe arriving while the grant is 0 leaves the byte unchanged through the following write-done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wren_stb | input | 1 | Set enable latch |
| wrdi_stb | input | 1 | Clear enable latch and flag |
| flag_set_stb | input | 1 | Set flag bit |
| srw_stb | input | 1 | Status write request |
| srw_data | input | 8 | Byte carried by the status write |
| wr_done_stb | input | 1 | Timed write has completed |
| timer_busy | input | 1 | Write timer busy level |
| wp_pin_n | input | 1 | Write-protect pin, low asserts protection |
| arr_addr | input | ADDR_W | Captured page address of an array write |
| status_byte | output | 8 | Status readback |
| arr_wr_ok | output | 1 | Array write permitted for arr_addr |
| srw_ok | output | 1 | Status write permitted |

## Verification
Both grants and bit 0 are combinational. The bench therefore samples them one time step after it changes the inputs, with no clock edge in between. Every strobe-driven bit in the status byte is registered once, so it is due one edge after the strobe. The bench drives strobes on a falling edge, lets one rising edge pass and samples at the next falling edge. A pending status write is checked twice: before its write-done strobe, when the byte must still hold the old value, and one edge after that strobe. The lock and grant sweep covers every lock setting, pin level, pin-enable value and latch value, over addresses spaced 64 bytes apart plus the region boundaries.

// File: rtl/sr_guard_pkg.sv
// Package: shared bit positions and sizes of the status byte.
// Assumes an 8-bit status word with fixed positions decoded by the command engine.
package sr_guard_pkg;
    localparam int SB_W     = 8;
    localparam int POS_PEN  = 7;
    localparam int POS_FLAG = 6;
    localparam int POS_LK1  = 3;
    localparam int POS_LK0  = 2;
    localparam int POS_WEL  = 1;
    localparam int POS_BUSY = 0;
    localparam int LOCK_W   = 2;

    typedef enum logic [LOCK_W-1:0] {
        LOCK_NONE    = 2'b00,
        LOCK_QUARTER = 2'b01,
        LOCK_HALF    = 2'b10,
        LOCK_ALL     = 2'b11
    } lock_e;
endpackage

// File: rtl/sr_lock_decode.sv
// Module: maps the lock field and an array address to a "locked" flag.
// Assumes the protected regions are the top quarter, the top half or the
// whole array, so only the two most significant address bits matter.
module sr_lock_decode
    import sr_guard_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  lock_e             lock,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    logic [1:0] hi;
    logic [ADDR_W-3:0] unused_low;
    assign hi = addr[TOP -: 2];
    assign unused_low = addr[ADDR_W-3:0];

    // Region compare per lock setting.
    always_comb begin
        unique case (lock)
            LOCK_NONE:    locked = 1'b0;
            LOCK_QUARTER: locked = (hi == 2'b11);
            LOCK_HALF:    locked = hi[1];
            default:      locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_grant_table.sv
// Module: protection table producing the array and status write grants.
// Assumes locked comes from sr_lock_decode and the pin is active low.
module sr_grant_table (
    input  logic wel,
    input  logic pin_en,
    input  logic wp_pin_n,
    input  logic locked,
    output logic arr_ok,
    output logic sr_ok
);
    // Grants: latch gates both; lock gates the array; pin and enable gate the status.
    always_comb begin
        arr_ok = wel & ~locked;
        sr_ok  = wel & ~(pin_en & ~wp_pin_n);
    end
endmodule

// File: rtl/sr_state.sv
// Module: volatile latch, flag, and preset-loaded protection bits with a
// pending status write that commits on write completion.
// Assumes strobes are single-cycle and sr_ok is evaluated in the strobe cycle.
module sr_state
    import sr_guard_pkg::*;
#(
    parameter logic  PEN_INIT  = 1'b0,
    parameter lock_e LOCK_INIT = LOCK_NONE
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wren_stb,
    input  logic             wrdi_stb,
    input  logic             flag_set_stb,
    input  logic             srw_stb,
    input  logic [SB_W-1:0]  srw_data,
    input  logic             wr_done_stb,
    input  logic             sr_ok,
    output logic             wel,
    output logic             flag,
    output logic             pin_en,
    output lock_e            lock
);
    logic        pend;
    logic        pend_pen;
    logic [1:0]  pend_lock;
    logic        unused_bits;

    assign unused_bits = ^{srw_data[POS_FLAG], srw_data[5:4], srw_data[POS_WEL], srw_data[POS_BUSY]};

    // Enable latch: set by enable, cleared by disable or write completion.
    always_ff @(posedge clk) begin
        if (!rst_n)                      wel <= 1'b0;
        else if (wrdi_stb | wr_done_stb) wel <= 1'b0;
        else if (wren_stb)               wel <= 1'b1;
    end

    // Flag: set by its strobe, cleared by disable.
    always_ff @(posedge clk) begin
        if (!rst_n)            flag <= 1'b0;
        else if (wrdi_stb)     flag <= 1'b0;
        else if (flag_set_stb) flag <= 1'b1;
    end

    // Pending status write: accepted only when granted, kept until completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend      <= 1'b0;
            pend_pen  <= 1'b0;
            pend_lock <= 2'b00;
        end else if (wr_done_stb) begin
            pend <= 1'b0;
        end else if (srw_stb && sr_ok && !pend) begin
            pend      <= 1'b1;
            pend_pen  <= srw_data[POS_PEN];
            pend_lock <= srw_data[POS_LK1:POS_LK0];
        end
    end

    // Protection bits: preset at reset, loaded when a pending write completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_en <= PEN_INIT;
            lock   <= LOCK_INIT;
        end else if (wr_done_stb && pend) begin
            pin_en <= pend_pen;
            lock   <= lock_e'(pend_lock);
        end
    end

    assert_wel_cleared_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_done_stb |=> !wel);
    assert_wel_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wren_stb && !wrdi_stb && !wr_done_stb) |=> wel);
    assert_flag_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wrdi_stb |=> !flag);
    assert_pending_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !wr_done_stb) |=> pend);
    assert_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && wr_done_stb) |=> (lock == lock_e'($past(pend_lock)) && pin_en == $past(pend_pen)));
    assert_bits_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(pend && wr_done_stb) |=> ($stable(lock) && $stable(pin_en)));
endmodule

// File: rtl/sr_guard.sv
// Module: top of the status register write-protection unit.
// Assumes a command engine supplies decoded single-cycle strobes, the timer
// busy level and the captured page address of an array write.
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int    ADDR_W      = 13,
    parameter logic  PIN_EN_INIT = 1'b0,
    parameter lock_e LOCK_INIT   = LOCK_NONE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wren_stb,
    input  logic              wrdi_stb,
    input  logic              flag_set_stb,
    input  logic              srw_stb,
    input  logic [7:0]        srw_data,
    input  logic              wr_done_stb,
    input  logic              timer_busy,
    input  logic              wp_pin_n,
    input  logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        status_byte,
    output logic              arr_wr_ok,
    output logic              srw_ok
);
    logic  wel, flag, pin_en, locked;
    lock_e lock;

    sr_state #(.PEN_INIT(PIN_EN_INIT), .LOCK_INIT(LOCK_INIT)) u_state (
        .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
        .flag_set_stb(flag_set_stb), .srw_stb(srw_stb), .srw_data(srw_data),
        .wr_done_stb(wr_done_stb), .sr_ok(srw_ok), .wel(wel), .flag(flag),
        .pin_en(pin_en), .lock(lock)
    );

    sr_lock_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr(arr_addr), .lock(lock), .locked(locked)
    );

    sr_grant_table u_table (
        .wel(wel), .pin_en(pin_en), .wp_pin_n(wp_pin_n), .locked(locked),
        .arr_ok(arr_wr_ok), .sr_ok(srw_ok)
    );

    // Readback assembly with the two fixed ones.
    always_comb begin
        status_byte = {pin_en, flag, 2'b11, lock, wel, timer_busy};
    end

    assert_full_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lock == LOCK_ALL) |-> !arr_wr_ok);
    assert_latch_gates_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !status_byte[POS_WEL] |-> (!arr_wr_ok && !srw_ok));
    assert_pin_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (status_byte[POS_PEN] && !wp_pin_n) |-> !srw_ok);
endmodule

// File: tb/sr_guard_tb.sv
`timescale 1ns/1ps
module sr_guard_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wren_stb = 0, wrdi_stb = 0, flag_set_stb = 0, srw_stb = 0, wr_done_stb = 0;
    logic timer_busy = 0, wp_pin_n = 1;
    logic [7:0] srw_data = 8'h00;
    logic [12:0] arr_addr = '0;
    logic [7:0] status_byte;
    logic arr_wr_ok, srw_ok;
    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    sr_guard u_dut (
        .clk(clk), .rst_n(rst_n), .wren_stb(wren_stb), .wrdi_stb(wrdi_stb),
        .flag_set_stb(flag_set_stb), .srw_stb(srw_stb), .srw_data(srw_data),
        .wr_done_stb(wr_done_stb), .timer_busy(timer_busy), .wp_pin_n(wp_pin_n),
        .arr_addr(arr_addr), .status_byte(status_byte), .arr_wr_ok(arr_wr_ok),
        .srw_ok(srw_ok)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle strobe: raise on a falling edge, drop on the next falling edge.
    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: wren_stb = 1; 1: wrdi_stb = 1; 2: flag_set_stb = 1;
            3: srw_stb = 1;  default: wr_done_stb = 1;
        endcase
        @(negedge clk);
        {wren_stb, wrdi_stb, flag_set_stb, srw_stb, wr_done_stb} = '0;
    endtask

    function automatic logic [7:0] sb(input logic pen, input logic flg,
                                      input logic [1:0] lk, input logic we, input logic bz);
        return {pen, flg, 2'b11, lk, we, bz};
    endfunction

    function automatic logic is_locked(input logic [1:0] lk, input int a);
        if (lk == 2'd3) return 1'b1;
        if (lk == 2'd2) return a >= 4096;
        if (lk == 2'd1) return a >= 6144;
        return 1'b0;
    endfunction

    // Program pin-enable and lock with the pin high, then leave the latch clear.
    task automatic program_sr(input logic pen, input logic [1:0] lk);
        wp_pin_n = 1;
        pulse(0);
        srw_data = {pen, 3'b000, lk, 2'b00};
        pulse(3);
        pulse(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset byte", status_byte, 8'h30);
        check("R7 no grant after reset", {6'b0, arr_wr_ok, srw_ok}, 8'h00);

        timer_busy = 1; #1;
        check("R5 busy follows", status_byte, 8'h31);
        timer_busy = 0; #1;
        check("R5 busy idle", status_byte, 8'h30);

        pulse(0);
        check("R2 enable sets latch", status_byte, 8'h32);
        pulse(2);
        check("R3 flag set", status_byte, 8'h72);
        pulse(1);
        check("R2 R3 disable clears both", status_byte, 8'h30);

        @(negedge clk); wren_stb = 1; wrdi_stb = 1;
        @(negedge clk); {wren_stb, wrdi_stb} = '0;
        check("R2 disable priority", status_byte, 8'h30);
        @(negedge clk); wren_stb = 1; wr_done_stb = 1;
        @(negedge clk); {wren_stb, wr_done_stb} = '0;
        check("R4 done priority", status_byte, 8'h30);
        pulse(0); pulse(4);
        check("R4 done clears latch", status_byte, 8'h30);

        // R6: write all ones; only pen and lock take effect.
        wp_pin_n = 1; pulse(0);
        srw_data = 8'hFF; pulse(3);
        check("R10 before done", status_byte, 8'h32);
        pulse(4);
        check("R6 masked write", status_byte, 8'hBC);
        srw_data = 8'h00;
        pulse(0); pulse(3); pulse(4);
        check("R6 clear write", status_byte, 8'h30);

        // R8/R9/R7 sweep.
        for (int pen = 0; pen < 2; pen++) begin
            for (int lk = 0; lk < 4; lk++) begin
                program_sr(pen[0], lk[1:0]);
                for (int we = 0; we < 2; we++) begin
                    if (we == 1) pulse(0);
                    for (int pin = 0; pin < 2; pin++) begin
                        wp_pin_n = pin[0]; #1;
                        check("R9 status grant", {7'b0, srw_ok},
                              {7'b0, we[0] & ~(pen[0] & ~pin[0])});
                        for (int a = 0; a < 8192; a += 64) begin
                            arr_addr = a[12:0]; #1;
                            check(we == 0 ? "R7 array grant" : "R8 array grant",
                                  {7'b0, arr_wr_ok}, {7'b0, we[0] & ~is_locked(lk[1:0], a)});
                        end
                        for (int k = 0; k < 6; k++) begin
                            int a;
                            a = (k == 0) ? 4095 : (k == 1) ? 4096 : (k == 2) ? 6143 :
                                (k == 3) ? 6144 : (k == 4) ? 0 : 8191;
                            arr_addr = a[12:0]; #1;
                            check("R8 boundary", {7'b0, arr_wr_ok},
                                  {7'b0, we[0] & ~is_locked(lk[1:0], a)});
                        end
                    end
                    wp_pin_n = 1;
                end
                pulse(1);
            end
        end

        // R10: accepted write survives pin going low.
        program_sr(1'b1, 2'b00);
        check("R10 pen set", status_byte, sb(1, 0, 2'b00, 0, 0));
        wp_pin_n = 1; pulse(0);
        srw_data = 8'h8C; pulse(3);
        wp_pin_n = 0;
        pulse(4);
        check("R10 no abort", status_byte, sb(1, 0, 2'b11, 0, 0));
        // Refused write with pin low and pin-enable set.
        pulse(0);
        srw_data = 8'h00; pulse(3);
        pulse(4);
        check("R10 refused write", status_byte, sb(1, 0, 2'b11, 0, 0));
        // Pin high again allows it.
        wp_pin_n = 1; pulse(0); pulse(3); pulse(4);
        check("R9 R10 pin high write", status_byte, 8'h30);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule